// File: doc/BRIEF.md
# Directory Coherence State Controller

This block keeps the coherence directory for a small distributed shared-memory machine. Each cache line has one directory entry. The entry holds three fields:

- a two-bit line state;
- an eight-bit identifier of the exclusive owner node;
- a presence bitmap with one bit per node.

Requests arrive over a valid/ready handshake. Each request carries an operation code, the node that issued it, and the line index. The block updates the entry on the edge that accepts the request. It then sends the coherence messages the request calls for on a message port, one per cycle.

A write fans out invalidations to every other holder of the line and records the writer as the exclusive owner. A read of a line that another node owns exclusively first sends a downgrade message to that owner. While messages are still pending, the block holds `req_ready` low so that no new request can race them. A combinational lookup port shows any entry, so the state is visible to the surrounding logic. Data transfer, memory contents and the network are outside this block.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset, every entry reads state uncached (2'b00), owner 0 and an empty bitmap. `req_ready` is high, and `busy` and `msg_valid` are low.
- R2: A read (op 2'b00) to an uncached or shared line sets the requester's bit and keeps every other bit. The line becomes shared (2'b01) with owner 0, and no message is sent.
- R3: A read by node n to a line that another node o owns exclusively sends exactly one downgrade message (kind 1) to node o. The message appears in the cycle after acceptance. The line becomes shared with only bits o and n set and owner 0.
- R4: A write (op 2'b01) by node n leaves the line exclusive (2'b10), with owner n zero-extended to 8 bits and only bit n set in the bitmap.
- R5: A write sends one invalidate message (kind 0) per cycle, starting the cycle after acceptance. The targets are every node other than the writer that held the line: the prior bitmap holders for a shared line, or the prior owner for an exclusive line. Targets go out in ascending node order, and the writer never receives one.
- R6: `busy` is high exactly while messages remain to be sent, and `req_ready` equals the inverse of `busy`. A request presented while `req_ready` is low has no effect on any entry.
- R7: A release (op 2'b10) by the exclusive owner returns the line to uncached with owner 0 and an empty bitmap. A release by any other node, or to a line that is not exclusive, changes nothing.
- R8: A read or write by the current exclusive owner sends no message and leaves the entry unchanged. Op code 2'b11 is ignored on every line.
- R9: Every message carries the line index of the request that caused it. The lookup port shows the entry selected by `lk_line` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 00 read, 01 write, 10 release, 11 ignored |
| req_node | input | 4 | Requesting node |
| req_line | input | 6 | Line index |
| msg_valid | output | 1 | Coherence message valid this cycle |
| msg_kind | output | 1 | 0 invalidate, 1 downgrade |
| msg_node | output | 4 | Target node of the message |
| msg_line | output | 6 | Line the message refers to |
| busy | output | 1 | Messages still pending |
| lk_line | input | 6 | Line to show on the lookup port |
| lk_state | output | 2 | State of the looked-up line |
| lk_owner | output | 8 | Owner field of the looked-up line |
| lk_sharers | output | 16 | Presence bitmap of the looked-up line |

## Verification
Each result is due at a fixed cycle after the stimulus:

- **Directory state:** the entry changes on the very edge that accepts a request, so the bench reads it back through the lookup port once the message burst has ended.
- **Messages:** the first message is valid in the cycle after acceptance, and each later target follows one cycle apart. The bench samples every message at the falling edge of its own cycle and compares it with the next set bit of a target mask computed by its own model.
- **Handshake:** `busy` and `req_ready` are checked in each of those cycles. One cycle after the last message, the bench confirms that the port is quiet again.
- **Stalled requests:** a request poked during a burst is checked for no effect on its line.

// File: rtl/dir_pkg.sv
// Package: shared encodings for the directory coherence controller.
// Assumes: line state is two bits, message kind is one bit.
package dir_pkg;

    typedef enum logic [1:0] {
        ST_UNCACHED = 2'b00,
        ST_SHARED   = 2'b01,
        ST_EXCL     = 2'b10
    } dir_state_t;

    typedef enum logic [1:0] {
        OP_READ    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_RELEASE = 2'b10,
        OP_NONE    = 2'b11
    } dir_op_t;

    typedef enum logic {
        MSG_INVAL = 1'b0,
        MSG_DOWN  = 1'b1
    } dir_msg_t;

endpackage

// File: rtl/dir_store.sv
// Module: dir_store
// Holds one directory entry per line in flops: state, owner field and
// presence bitmap. One write port, one read port for the request path and
// one read port for the lookup path.
// Assumes: writes come only from an accepted request. Reset is synchronous and active low.
module dir_store
    import dir_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int NODES  = 16,
    parameter int OWN_W  = 8,
    localparam int LW    = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  dir_state_t       wr_state,
    input  logic [OWN_W-1:0] wr_owner,
    input  logic [NODES-1:0] wr_sharers,
    input  logic [LW-1:0]    rd_line,
    output dir_state_t       rd_state,
    output logic [OWN_W-1:0] rd_owner,
    output logic [NODES-1:0] rd_sharers,
    input  logic [LW-1:0]    lk_line,
    output dir_state_t       lk_state,
    output logic [OWN_W-1:0] lk_owner,
    output logic [NODES-1:0] lk_sharers
);

    dir_state_t       st_q  [LINES];
    logic [OWN_W-1:0] own_q [LINES];
    logic [NODES-1:0] sh_q  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_entry
        // Per-line entry register: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= ST_UNCACHED;
                own_q[g] <= '0;
                sh_q[g]  <= '0;
            end else if (wr_en && (wr_line == LW'(g))) begin
                st_q[g]  <= wr_state;
                own_q[g] <= wr_owner;
                sh_q[g]  <= wr_sharers;
            end
        end

        // R4
        excl_single_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == ST_EXCL) |-> ($countones(sh_q[g]) == 1));
        // R7
        uncached_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == ST_UNCACHED) |-> (sh_q[g] == '0 && own_q[g] == '0));
        // R2
        shared_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == ST_SHARED) |-> (sh_q[g] != '0));
    end

    // Read port for the request path.
    always_comb begin
        rd_state   = st_q[rd_line];
        rd_owner   = own_q[rd_line];
        rd_sharers = sh_q[rd_line];
    end

    // Read port for the lookup path.
    always_comb begin
        lk_state   = st_q[lk_line];
        lk_owner   = own_q[lk_line];
        lk_sharers = sh_q[lk_line];
    end

endmodule

// File: rtl/dir_policy.sv
// Module: dir_policy
// Combinational coherence policy. From the current entry and the request it
// works out the next entry, whether the entry changes, and the set of nodes
// to message along with the message kind.
// Assumes: NODES is a power of two no larger than 2**OWN_W.
module dir_policy
    import dir_pkg::*;
#(
    parameter int NODES  = 16,
    parameter int OWN_W  = 8,
    localparam int NW    = $clog2(NODES)
) (
    input  dir_op_t          op,
    input  logic [NW-1:0]    node,
    input  dir_state_t       cur_state,
    input  logic [OWN_W-1:0] cur_owner,
    input  logic [NODES-1:0] cur_sharers,
    output logic             upd,
    output dir_state_t       nxt_state,
    output logic [OWN_W-1:0] nxt_owner,
    output logic [NODES-1:0] nxt_sharers,
    output logic [NODES-1:0] tgt_mask,
    output dir_msg_t         tgt_kind
);

    logic [NODES-1:0] me_bit;
    logic [NODES-1:0] own_bit;
    logic             is_owner;

    // Decode the requester and owner into one-hot node masks.
    always_comb begin
        me_bit   = NODES'(1) << node;
        own_bit  = NODES'(1) << cur_owner[NW-1:0];
        is_owner = (cur_state == ST_EXCL) && (cur_owner == OWN_W'(node));
    end

    // Next-state and message-target selection per operation.
    always_comb begin
        upd         = 1'b0;
        nxt_state   = cur_state;
        nxt_owner   = cur_owner;
        nxt_sharers = cur_sharers;
        tgt_mask    = '0;
        tgt_kind    = MSG_INVAL;
        unique case (op)
            OP_READ: begin
                if (!is_owner) begin
                    upd       = 1'b1;
                    nxt_state = ST_SHARED;
                    nxt_owner = '0;
                    if (cur_state == ST_EXCL) begin
                        tgt_mask    = own_bit;
                        tgt_kind    = MSG_DOWN;
                        nxt_sharers = own_bit | me_bit;
                    end else begin
                        nxt_sharers = cur_sharers | me_bit;
                    end
                end
            end
            OP_WRITE: begin
                if (!is_owner) begin
                    upd         = 1'b1;
                    nxt_state   = ST_EXCL;
                    nxt_owner   = OWN_W'(node);
                    nxt_sharers = me_bit;
                    tgt_kind    = MSG_INVAL;
                    if (cur_state == ST_EXCL)
                        tgt_mask = own_bit & ~me_bit;
                    else if (cur_state == ST_SHARED)
                        tgt_mask = cur_sharers & ~me_bit;
                end
            end
            OP_RELEASE: begin
                if (is_owner) begin
                    upd         = 1'b1;
                    nxt_state   = ST_UNCACHED;
                    nxt_owner   = '0;
                    nxt_sharers = '0;
                end
            end
            default: begin
                upd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dir_msg_seq.sv
// Module: dir_msg_seq
// Holds the pending target mask of the last accepted request and emits one
// message per cycle to the lowest-numbered pending node, then clears it.
// Assumes: load is only raised while nothing is pending.
module dir_msg_seq
    import dir_pkg::*;
#(
    parameter int NODES = 16,
    parameter int LINES = 64,
    localparam int NW   = $clog2(NODES),
    localparam int LW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NODES-1:0] load_mask,
    input  dir_msg_t         load_kind,
    input  logic [LW-1:0]    load_line,
    input  logic [NW-1:0]    load_node,
    output logic             msg_valid,
    output dir_msg_t         msg_kind,
    output logic [NW-1:0]    msg_node,
    output logic [LW-1:0]    msg_line
);

    logic [NODES-1:0] pend_q;
    dir_msg_t         kind_q;
    logic [LW-1:0]    line_q;
    logic [NW-1:0]    src_q;
    logic [NW-1:0]    pick;

    // Priority pick of the lowest pending node.
    always_comb begin
        pick = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = NW'(i);
        end
    end

    // Pending mask and message context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            kind_q <= MSG_INVAL;
            line_q <= '0;
            src_q  <= '0;
        end else if (load) begin
            pend_q <= load_mask;
            kind_q <= load_kind;
            line_q <= load_line;
            src_q  <= load_node;
        end else if (pend_q != '0) begin
            pend_q <= pend_q & ~(NODES'(1) << pick);
        end
    end

    // Drive the message port from the pending state.
    always_comb begin
        msg_valid = (pend_q != '0);
        msg_kind  = kind_q;
        msg_node  = pick;
        msg_line  = line_q;
    end

    // R5
    ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && $past(msg_valid) && !$past(load)) |-> (msg_node > $past(msg_node)));
    // R5
    not_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_INVAL) |-> (msg_node != src_q));
    // R6
    one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !load) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
    // R3
    single_downgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_DOWN && !load) |=> !msg_valid);

endmodule

// File: rtl/dir_coherence_ctrl.sv
// Module: dir_coherence_ctrl
// Top of the directory coherence controller. Accepts a request when nothing
// is pending, updates the entry on the accepting edge, and hands the message
// targets to the sequencer. The request port stalls while messages drain.
// Assumes: 16 nodes and 64 lines by default; owner field 8 bits wide.
module dir_coherence_ctrl
    import dir_pkg::*;
#(
    parameter int NODES = 16,
    parameter int LINES = 64,
    parameter int OWN_W = 8,
    localparam int NW   = $clog2(NODES),
    localparam int LW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [NW-1:0]    req_node,
    input  logic [LW-1:0]    req_line,
    output logic             msg_valid,
    output logic             msg_kind,
    output logic [NW-1:0]    msg_node,
    output logic [LW-1:0]    msg_line,
    output logic             busy,
    input  logic [LW-1:0]    lk_line,
    output logic [1:0]       lk_state,
    output logic [OWN_W-1:0] lk_owner,
    output logic [NODES-1:0] lk_sharers
);

    dir_state_t       cur_state, nxt_state, lk_st;
    logic [OWN_W-1:0] cur_owner, nxt_owner;
    logic [NODES-1:0] cur_sharers, nxt_sharers, tgt_mask;
    dir_msg_t         tgt_kind, seq_kind;
    logic             upd, accept, wr_en;

    // Handshake: accept only when the sequencer is idle.
    always_comb begin
        busy      = msg_valid;
        req_ready = !busy;
        accept    = req_valid && req_ready;
        wr_en     = accept && upd;
        msg_kind  = seq_kind;
        lk_state  = lk_st;
    end

    dir_store #(.LINES(LINES), .NODES(NODES), .OWN_W(OWN_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_line    (req_line),
        .wr_state   (nxt_state),
        .wr_owner   (nxt_owner),
        .wr_sharers (nxt_sharers),
        .rd_line    (req_line),
        .rd_state   (cur_state),
        .rd_owner   (cur_owner),
        .rd_sharers (cur_sharers),
        .lk_line    (lk_line),
        .lk_state   (lk_st),
        .lk_owner   (lk_owner),
        .lk_sharers (lk_sharers)
    );

    dir_policy #(.NODES(NODES), .OWN_W(OWN_W)) u_policy (
        .op          (dir_op_t'(req_op)),
        .node        (req_node),
        .cur_state   (cur_state),
        .cur_owner   (cur_owner),
        .cur_sharers (cur_sharers),
        .upd         (upd),
        .nxt_state   (nxt_state),
        .nxt_owner   (nxt_owner),
        .nxt_sharers (nxt_sharers),
        .tgt_mask    (tgt_mask),
        .tgt_kind    (tgt_kind)
    );

    dir_msg_seq #(.NODES(NODES), .LINES(LINES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_mask (tgt_mask),
        .load_kind (tgt_kind),
        .load_line (req_line),
        .load_node (req_node),
        .msg_valid (msg_valid),
        .msg_kind  (seq_kind),
        .msg_node  (msg_node),
        .msg_line  (msg_line)
    );

    // R6
    no_write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !wr_en);
    // R9
    msg_line_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && $past(msg_valid) && $past(rst_n)) |-> $stable(msg_line));
    // R5
    first_msg_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tgt_mask != '0) |=> msg_valid);

endmodule

// File: tb/tb_dir_coherence_ctrl.sv
// Bench for dir_coherence_ctrl: directed corner cases, then seeded random
// requests, each compared with a reference directory kept by the bench.
module tb_dir_coherence_ctrl;

    localparam int NODES = 16;
    localparam int LINES = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [3:0]  req_node = '0;
    logic [5:0]  req_line = '0;
    logic        msg_valid, msg_kind, busy;
    logic [3:0]  msg_node;
    logic [5:0]  msg_line;
    logic [5:0]  lk_line = '0;
    logic [1:0]  lk_state;
    logic [7:0]  lk_owner;
    logic [15:0] lk_sharers;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0]  m_st [LINES];
    logic [7:0]  m_own[LINES];
    logic [15:0] m_sh [LINES];

    always #10 clk = ~clk;

    dir_coherence_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_node(req_node), .req_line(req_line),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
        .msg_line(msg_line), .busy(busy), .lk_line(lk_line), .lk_state(lk_state),
        .lk_owner(lk_owner), .lk_sharers(lk_sharers)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: next entry plus message targets and kind.
    task automatic model(input logic [1:0] op, input logic [3:0] n, input logic [5:0] l,
                         output logic [15:0] tgt, output logic kind);
        logic [15:0] me = 16'(1) << n;
        logic [15:0] ob = 16'(1) << m_own[l][3:0];
        bit own = (m_st[l] == 2'b10) && (m_own[l] == {4'b0, n});
        tgt = '0;
        kind = 1'b0;
        if (op == 2'b00 && !own) begin
            if (m_st[l] == 2'b10) begin
                tgt = ob; kind = 1'b1; m_sh[l] = ob | me;
            end else m_sh[l] = m_sh[l] | me;
            m_st[l] = 2'b01; m_own[l] = '0;
        end else if (op == 2'b01 && !own) begin
            if (m_st[l] == 2'b10) tgt = ob & ~me;
            else if (m_st[l] == 2'b01) tgt = m_sh[l] & ~me;
            m_st[l] = 2'b10; m_own[l] = {4'b0, n}; m_sh[l] = me;
        end else if (op == 2'b10 && own) begin
            m_st[l] = 2'b00; m_own[l] = '0; m_sh[l] = '0;
        end
    endtask

    task automatic check_entry(input logic [5:0] l, input string req);
        lk_line = l;
        #1;
        chk(lk_state == m_st[l], req, "state", 32'(lk_state), 32'(m_st[l]));
        chk(lk_owner == m_own[l], req, "owner", 32'(lk_owner), 32'(m_own[l]));
        chk(lk_sharers == m_sh[l], req, "sharers", 32'(lk_sharers), 32'(m_sh[l]));
    endtask

    // Issue one request at a falling edge, then check each message cycle.
    // With poke set, a request to poke_line is held up during the first message.
    task automatic issue(input logic [1:0] op, input logic [3:0] n, input logic [5:0] l,
                         input string req, input bit poke, input logic [5:0] poke_line);
        logic [15:0] tgt;
        logic        kind;
        bit          poked = 0;
        chk(req_ready == 1'b1, "R6", "ready before request", 32'(req_ready), 32'd1);
        model(op, n, l, tgt, kind);
        req_valid = 1'b1; req_op = op; req_node = n; req_line = l;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            if (tgt[i]) begin
                chk(msg_valid == 1'b1, req, "msg_valid", 32'(msg_valid), 32'd1);
                chk(msg_node == 4'(i), req, "msg_node", 32'(msg_node), 32'(i));
                chk(msg_kind == kind, req, "msg_kind", 32'(msg_kind), 32'(kind));
                chk(msg_line == l, "R9", "msg_line", 32'(msg_line), 32'(l));
                chk(busy && !req_ready, "R6", "busy/ready", {busy, req_ready}, 32'b10);
                if (poke && !poked) begin
                    req_valid = 1'b1; req_op = 2'b01; req_node = 4'd15; req_line = poke_line;
                    poked = 1;
                end
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        chk(!msg_valid && !busy && req_ready, "R6", "idle after burst",
            {msg_valid, busy, req_ready}, 32'b001);
        check_entry(l, req);
        if (poked) check_entry(poke_line, "R6");
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog", "timeout", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int l = 0; l < LINES; l++) begin
            m_st[l] = '0; m_own[l] = '0; m_sh[l] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of all entries and handshake
        chk(!msg_valid && !busy && req_ready, "R1", "idle after reset",
            {msg_valid, busy, req_ready}, 32'b001);
        for (int l = 0; l < LINES; l++) check_entry(6'(l), "R1");

        // R2: reads build up sharers
        issue(2'b00, 4'd3, 6'd5, "R2", 0, 0);
        issue(2'b00, 4'd9, 6'd5, "R2", 0, 0);
        issue(2'b00, 4'd0, 6'd5, "R2", 0, 0);
        // R5: write by node 9 invalidates 0 and 3; poke line 6 while busy (R6)
        issue(2'b01, 4'd9, 6'd5, "R5", 1, 6'd6);
        // R8: owner reads and writes, no messages
        issue(2'b00, 4'd9, 6'd5, "R8", 0, 0);
        issue(2'b01, 4'd9, 6'd5, "R8", 0, 0);
        issue(2'b11, 4'd2, 6'd5, "R8", 0, 0);
        // R3: read by another node downgrades the owner
        issue(2'b00, 4'd12, 6'd5, "R3", 0, 0);
        // R7: release by non-owner and on shared line ignored
        issue(2'b10, 4'd12, 6'd5, "R7", 0, 0);
        // R4: write by a new node, then a foreign release is ignored
        issue(2'b01, 4'd4, 6'd5, "R4", 0, 0);
        issue(2'b10, 4'd7, 6'd5, "R7", 0, 0);
        // R5: write to exclusive line invalidates prior owner
        issue(2'b01, 4'd7, 6'd5, "R5", 0, 0);
        issue(2'b10, 4'd7, 6'd5, "R7", 0, 0);
        // R5: all 16 nodes share line 63, node 0 writes: 15 invalidates
        for (int n = 0; n < NODES; n++) issue(2'b00, 4'(n), 6'd63, "R2", 0, 0);
        issue(2'b01, 4'd0, 6'd63, "R5", 1, 6'd62);
        // R4: write to uncached line
        issue(2'b01, 4'd15, 6'd0, "R4", 0, 0);

        // Random mix on a few lines
        for (int k = 0; k < 400; k++) begin
            logic [5:0] l = ($urandom % 2) ? 6'($urandom % 4) : 6'(60 + $urandom % 4);
            issue(2'($urandom % 4), 4'($urandom % 16), l, "R5", ($urandom % 4) == 0,
                  6'($urandom % 64));
        end
        for (int l = 0; l < LINES; l++) check_entry(6'(l), "R9");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule